// File: doc/BRIEF.md
# SIMD Register Move and Merge Unit

This block holds a bank of wide vector registers and carries out the plain data-movement operations on them: scalar moves, full-width and half-width packed moves, and stores. It decodes the class of the mandatory prefix, the second opcode byte and an encoding flag for the three-byte vector form. From these it picks the operand width and the rule for the untouched upper bits of the destination. Every register write is a merge: one field is replaced, another may be cleared, and the rest keeps its old value.

The unit sits after address generation and fetch. It receives the instruction length and the low four address bits for fault checks, and a memory data word for loads. For stores it returns a memory data word. Faults are reported as a one-cycle pulse with a code. A faulting operation writes no register and drives no store. A read port lets the datapath around the block fetch any register.

Top module: `simd_mv_unit`

## Requirements
- R1: After reset every register reads as zero, and `st_valid` and `fault_valid` are low.
- R2: An operation presented with `op_valid` high is sampled on a rising edge. Its register write, its store output and its fault pulse all appear after that edge. Source reads use the register values from before the write.
- R3: With a register source, prefix class 3 (F3) or 2 (F2) with opcode 0x10 replaces bits 31:0 or 63:0 of the destination with the source's low bits. All other bits are kept.
- R4: With a memory source, the same scalar loads place the low 32 or 64 bits of the memory word in the destination. Destination bits up to 127 above that width are cleared, and bits above 127 are kept.
- R5: Without the vector flag, a 128-bit load replaces bits 127:0 and keeps the bits above. The 128-bit loads are opcode 0x10 or 0x28 with prefix class 0 (none) or 1 (66), and opcode 0x6F with prefix class 3.
- R6: Opcodes 0x28 and 0x29 with a memory operand and `op_addr_lo` not zero raise `fault_code` 1 (alignment). No other operation faults on the address.
- R7: With a memory source and prefix class 0 or 1, opcode 0x12 replaces only bits 63:0. Opcode 0x16 replaces bits 127:64 with the memory word's low 64 bits and keeps bits 63:0.
- R8: Opcode 0x12 with prefix class 0 and a register source copies source bits 127:64 into destination bits 63:0 and keeps all other destination bits.
- R9: A store to memory drives `st_valid` for one cycle with the `op_reg` register's low 32, 64, 128 or 256 bits, zero-extended. Opcode 0x13 gives bits 63:0 and opcode 0x17 gives bits 127:64, both in `st_data[63:0]`. Opcodes 0x11, 0x29 and 0x7F are the full-width stores.
- R10: A store opcode (0x11, 0x29, 0x7F) with a register operand writes the `op_rm` register from the `op_reg` register. It follows the register-source merge rule for its width.
- R11: With the vector flag set and prefix class 0, opcodes 0x10 and 0x11 move 256 bits when `op_vex_l` is 1 and 128 bits when it is 0. All destination bits above that width are cleared, and no alignment fault is raised.
- R12: An `op_len` above 15 raises `fault_code` 2 for any operation. This takes priority over alignment and suppresses the write and the store.
- R13: Any other combination, such as prefix class 1 with opcode 0x12 and a register source, or the vector flag with a nonzero prefix class, writes nothing, stores nothing and raises no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_pfx | input | 2 | Prefix class: 0 none, 1 66, 2 F2, 3 F3 |
| op_code | input | 8 | Opcode byte following 0x0F |
| op_vex | input | 1 | Three-byte vector encoding flag |
| op_vex_l | input | 1 | Vector length bit (1 = 256-bit) |
| op_reg | input | IDX_W | Register field index |
| op_src_mem | input | 1 | 1 = memory operand, 0 = register operand |
| op_rm | input | IDX_W | Register operand index when not memory |
| op_mem_data | input | 256 | Memory data word for loads |
| op_addr_lo | input | 4 | Low address bits of the memory operand |
| op_len | input | LEN_W | Total instruction length in bytes |
| peek_idx | input | IDX_W | Read port index |
| peek_data | output | VLEN | Read port data |
| st_valid | output | 1 | Store data valid pulse |
| st_data | output | 256 | Store data, zero-extended |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 alignment, 2 length |

## Verification
The assertions assume that every operation field is stable and defined whenever `op_valid` is high. They also assume that `op_len` and `op_addr_lo` describe the same operation as the opcode. The bench holds inputs for exactly one sampling edge and drops `op_valid` in the cycle after. It sweeps every prefix class, every listed opcode plus an unused one, both encodings, both length bits, both operand kinds, aligned and misaligned addresses, and lengths of 15 and 16. A shadow register bank in the bench gives the expected merge result for each step.

// File: rtl/simd_mv_pkg.sv
`timescale 1ns/1ps
package simd_mv_pkg;
   localparam int MV_MEM_W = 256;

   typedef enum logic [1:0] {
      PFX_NONE = 2'd0,
      PFX_66   = 2'd1,
      PFX_F2   = 2'd2,
      PFX_F3   = 2'd3
   } mv_pfx_e;

   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_LOAD  = 2'd1,
      K_STORE = 2'd2
   } mv_kind_e;

   typedef enum logic [2:0] {
      F_S32  = 3'd0,
      F_S64  = 3'd1,
      F_V128 = 3'd2,
      F_V256 = 3'd3,
      F_LO64 = 3'd4,
      F_HI64 = 3'd5,
      F_HL   = 3'd6
   } mv_fmt_e;

   localparam logic [1:0] FLT_ALIGN = 2'd1;
   localparam logic [1:0] FLT_LEN   = 2'd2;
endpackage

// File: rtl/simd_mv_decode.sv
`timescale 1ns/1ps
module simd_mv_decode
   import simd_mv_pkg::*;
(
   input  logic [1:0] pfx,
   input  logic [7:0] code,
   input  logic       vex,
   input  logic       vex_l,
   input  logic       src_mem,
   output mv_kind_e   kind,
   output mv_fmt_e    fmt,
   output logic       align_req
);
   logic pfx_pk;
   assign pfx_pk = (pfx == PFX_NONE) || (pfx == PFX_66);

   always_comb begin
      kind      = K_NONE;
      fmt       = F_V128;
      align_req = 1'b0;
      if (vex) begin
         if (pfx == PFX_NONE && (code == 8'h10 || code == 8'h11)) begin
            kind = code[0] ? K_STORE : K_LOAD;
            fmt  = vex_l ? F_V256 : F_V128;
         end
      end else begin
         case (code)
            8'h10, 8'h11: begin
               kind = code[0] ? K_STORE : K_LOAD;
               fmt  = (pfx == PFX_F3) ? F_S32 : (pfx == PFX_F2) ? F_S64 : F_V128;
            end
            8'h28, 8'h29: if (pfx_pk) begin
               kind      = code[0] ? K_STORE : K_LOAD;
               align_req = 1'b1;
            end
            8'h6F: if (pfx == PFX_F3) kind = K_LOAD;
            8'h7F: if (pfx == PFX_F3) kind = K_STORE;
            8'h12: begin
               if (pfx_pk && src_mem) begin
                  kind = K_LOAD;
                  fmt  = F_LO64;
               end else if (pfx == PFX_NONE && !src_mem) begin
                  kind = K_LOAD;
                  fmt  = F_HL;
               end
            end
            8'h13: if (pfx_pk && src_mem) begin
               kind = K_STORE;
               fmt  = F_LO64;
            end
            8'h16: if (pfx_pk && src_mem) begin
               kind = K_LOAD;
               fmt  = F_HI64;
            end
            8'h17: if (pfx_pk && src_mem) begin
               kind = K_STORE;
               fmt  = F_HI64;
            end
            default: kind = K_NONE;
         endcase
      end
   end
endmodule

// File: rtl/simd_mv_merge.sv
`timescale 1ns/1ps
module simd_mv_merge
   import simd_mv_pkg::*;
#(
   parameter int VLEN = 512
) (
   input  mv_fmt_e           fmt,
   input  logic              from_mem,
   input  logic              vex,
   input  logic [VLEN-1:0]   old_val,
   input  logic [VLEN-1:0]   src_val,
   output logic [VLEN-1:0]   new_val
);
   localparam logic [VLEN-1:0] ONES = '1;
   localparam logic [VLEN-1:0] M32  = ONES >> (VLEN - 32);
   localparam logic [VLEN-1:0] M64  = ONES >> (VLEN - 64);
   localparam logic [VLEN-1:0] M128 = ONES >> (VLEN - 128);
   localparam logic [VLEN-1:0] M256 = ONES >> (VLEN - 256);

   logic [VLEN-1:0] repl, clr, placed;

   always_comb begin
      placed = src_val;
      clr    = '0;
      case (fmt)
         F_S32:   repl = M32;
         F_S64:   repl = M64;
         F_V128:  repl = M128;
         F_V256:  repl = M256;
         F_LO64:  repl = M64;
         F_HI64: begin
            repl   = M128 & ~M64;
            placed = src_val << 64;
         end
         F_HL: begin
            repl   = M64;
            placed = src_val >> 64;
         end
         default: repl = '0;
      endcase
      if (vex)
         clr = ~repl;
      else if (from_mem && (fmt == F_S32 || fmt == F_S64))
         clr = M128 & ~repl;
      new_val = (old_val & ~(repl | clr)) | (placed & repl);
   end
endmodule

// File: rtl/simd_mv_regfile.sv
`timescale 1ns/1ps
module simd_mv_regfile #(
   parameter int NREG = 16,
   parameter int VLEN = 512,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [VLEN-1:0]   w_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [IDX_W-1:0]  rp_idx,
   output logic [VLEN-1:0]   ra_data,
   output logic [VLEN-1:0]   rb_data,
   output logic [VLEN-1:0]   rp_data
);
   logic [VLEN-1:0] bank [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[g] <= '0;
         else if (we && w_idx == IDX_W'(g))
            bank[g] <= w_data;
      end
   end

   assign ra_data = bank[ra_idx];
   assign rb_data = bank[rb_idx];
   assign rp_data = bank[rp_idx];
endmodule

// File: rtl/simd_mv_unit.sv
`timescale 1ns/1ps
module simd_mv_unit
   import simd_mv_pkg::*;
#(
   parameter int NREG    = 16,
   parameter int VLEN    = 512,
   parameter int LEN_W   = 5,
   parameter int MAX_LEN = 15,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [1:0]           op_pfx,
   input  logic [7:0]           op_code,
   input  logic                 op_vex,
   input  logic                 op_vex_l,
   input  logic [IDX_W-1:0]     op_reg,
   input  logic                 op_src_mem,
   input  logic [IDX_W-1:0]     op_rm,
   input  logic [MV_MEM_W-1:0]  op_mem_data,
   input  logic [3:0]           op_addr_lo,
   input  logic [LEN_W-1:0]     op_len,
   input  logic [IDX_W-1:0]     peek_idx,
   output logic [VLEN-1:0]      peek_data,
   output logic                 st_valid,
   output logic [MV_MEM_W-1:0]  st_data,
   output logic                 fault_valid,
   output logic [1:0]           fault_code
);
   if (VLEN < MV_MEM_W || (VLEN % 128) != 0) begin : g_bad_vlen
      $error("VLEN must be a multiple of 128 and at least 256");
   end
   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two");
   end
   if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow to express a length above MAX_LEN");
   end

   mv_kind_e        kind;
   mv_fmt_e         fmt;
   logic            align_req;
   logic            len_bad, misalign, go, is_load, rf_we, st_fire;
   logic [VLEN-1:0] ra_data, rb_data, old_val, src_val, wr_val;
   logic [IDX_W-1:0] w_idx;
   logic [MV_MEM_W-1:0] st_next;

   simd_mv_decode u_dec (
      .pfx(op_pfx), .code(op_code), .vex(op_vex), .vex_l(op_vex_l),
      .src_mem(op_src_mem), .kind(kind), .fmt(fmt), .align_req(align_req)
   );

   assign len_bad  = op_len > LEN_W'(MAX_LEN);
   assign misalign = align_req && op_src_mem && (op_addr_lo != 4'd0);
   assign go       = op_valid && !len_bad && !misalign;
   assign is_load  = (kind == K_LOAD);
   assign rf_we    = go && (is_load || (kind == K_STORE && !op_src_mem));
   assign st_fire  = go && (kind == K_STORE) && op_src_mem;

   // Loads write the register field; register-form stores write the rm register.
   assign w_idx   = is_load ? op_reg : op_rm;
   assign old_val = is_load ? rb_data : ra_data;
   assign src_val = !is_load ? rb_data :
                    op_src_mem ? VLEN'(op_mem_data) : ra_data;

   simd_mv_merge #(.VLEN(VLEN)) u_merge (
      .fmt(fmt), .from_mem(op_src_mem && is_load), .vex(op_vex),
      .old_val(old_val), .src_val(src_val), .new_val(wr_val)
   );

   simd_mv_regfile #(.NREG(NREG), .VLEN(VLEN)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .w_idx(w_idx), .w_data(wr_val),
      .ra_idx(op_rm), .rb_idx(op_reg), .rp_idx(peek_idx),
      .ra_data(ra_data), .rb_data(rb_data), .rp_data(peek_data)
   );

   always_comb begin
      case (fmt)
         F_S32:   st_next = MV_MEM_W'(rb_data[31:0]);
         F_S64:   st_next = MV_MEM_W'(rb_data[63:0]);
         F_V128:  st_next = MV_MEM_W'(rb_data[127:0]);
         F_V256:  st_next = rb_data[MV_MEM_W-1:0];
         F_LO64:  st_next = MV_MEM_W'(rb_data[63:0]);
         F_HI64:  st_next = MV_MEM_W'(rb_data[127:64]);
         default: st_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_valid    <= 1'b0;
         st_data     <= '0;
         fault_valid <= 1'b0;
         fault_code  <= 2'd0;
      end else begin
         st_valid    <= st_fire;
         if (st_fire) st_data <= st_next;
         fault_valid <= op_valid && (len_bad || misalign);
         fault_code  <= !op_valid ? 2'd0 : len_bad ? FLT_LEN :
                        misalign ? FLT_ALIGN : 2'd0;
      end
   end

   // R12
   len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_len > LEN_W'(MAX_LEN)) |=> (fault_valid && fault_code == FLT_LEN));
   // R6
   align_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_len <= LEN_W'(MAX_LEN) && !op_vex && op_src_mem &&
       op_pfx[1] == 1'b0 && (op_code == 8'h28 || op_code == 8'h29) && op_addr_lo != 4'd0)
      |=> (fault_valid && fault_code == FLT_ALIGN));
   // R12
   fault_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !st_valid);
   // R11
   vex_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && op_vex) |-> ((wr_val >> MV_MEM_W) == '0));
   // R11
   vex_no_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_vex && op_len <= LEN_W'(MAX_LEN)) |=> !fault_valid);
endmodule

// File: tb/tb_simd_mv_unit.sv
`timescale 1ns/1ps
module tb_simd_mv_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [1:0]   op_pfx = '0;
   logic [7:0]   op_code = '0;
   logic         op_vex = 1'b0, op_vex_l = 1'b0, op_src_mem = 1'b0;
   logic [3:0]   op_reg = '0, op_rm = '0, op_addr_lo = '0, peek_idx = '0;
   logic [255:0] op_mem_data = '0;
   logic [4:0]   op_len = 5'd4;
   logic [511:0] peek_data;
   logic         st_valid, fault_valid;
   logic [255:0] st_data;
   logic [1:0]   fault_code;

   int checks = 0;
   int errors = 0;
   logic [511:0] sh [16];

   always #2 clk = ~clk;

   simd_mv_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_pfx(op_pfx),
      .op_code(op_code), .op_vex(op_vex), .op_vex_l(op_vex_l), .op_reg(op_reg),
      .op_src_mem(op_src_mem), .op_rm(op_rm), .op_mem_data(op_mem_data),
      .op_addr_lo(op_addr_lo), .op_len(op_len), .peek_idx(peek_idx),
      .peek_data(peek_data), .st_valid(st_valid), .st_data(st_data),
      .fault_valid(fault_valid), .fault_code(fault_code)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [255:0] rnd256();
      logic [255:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic run_op(input logic [1:0] pfx, input logic [7:0] code,
                         input logic vex, input logic l, input logic mem,
                         input logic [3:0] rg, input logic [3:0] rm,
                         input logic [3:0] alo, input logic [4:0] len);
      logic [255:0] md, esd;
      logic [511:0] src, ex;
      int kind, fmt;
      bit alreq, efv, esv, wr;
      logic [1:0] efc;
      logic [3:0] tgt;
      string tag;
      md = rnd256();
      kind = 0; fmt = 2; alreq = 0;
      if (vex) begin
         if (pfx == 0 && (code == 8'h10 || code == 8'h11)) begin
            kind = (code == 8'h10) ? 1 : 2; fmt = l ? 3 : 2;
         end
      end else begin
         case (code)
            8'h10, 8'h11: begin
               kind = (code == 8'h10) ? 1 : 2;
               fmt = (pfx == 3) ? 0 : (pfx == 2) ? 1 : 2;
            end
            8'h28, 8'h29: if (pfx < 2) begin kind = (code == 8'h28) ? 1 : 2; alreq = 1; end
            8'h6F: if (pfx == 3) kind = 1;
            8'h7F: if (pfx == 3) kind = 2;
            8'h12: if (pfx < 2 && mem) begin kind = 1; fmt = 4; end
                   else if (pfx == 0 && !mem) begin kind = 1; fmt = 6; end
            8'h13: if (pfx < 2 && mem) begin kind = 2; fmt = 4; end
            8'h16: if (pfx < 2 && mem) begin kind = 1; fmt = 5; end
            8'h17: if (pfx < 2 && mem) begin kind = 2; fmt = 5; end
            default: kind = 0;
         endcase
      end
      efv = 0; efc = 0;
      if (len > 5'd15) begin efv = 1; efc = 2; end
      else if (kind != 0 && alreq && mem && alo != 0) begin efv = 1; efc = 1; end
      if (efv) kind = 0;
      esv = (kind == 2) && mem;
      wr = (kind == 1) || (kind == 2 && !mem);
      tgt = (kind == 2) ? rm : rg;
      ex = sh[tgt];
      src = (kind == 2) ? sh[rg] : (mem ? {256'b0, md} : sh[rm]);
      esd = '0;
      case (fmt)
         0: esd = {224'b0, sh[rg][31:0]};
         1: esd = {192'b0, sh[rg][63:0]};
         2: esd = {128'b0, sh[rg][127:0]};
         3: esd = sh[rg][255:0];
         4: esd = {192'b0, sh[rg][63:0]};
         5: esd = {192'b0, sh[rg][127:64]};
         default: esd = '0;
      endcase
      if (wr) begin
         case (fmt)
            0: begin ex[31:0] = src[31:0]; if (mem) ex[127:32] = '0; end
            1: begin ex[63:0] = src[63:0]; if (mem) ex[127:64] = '0; end
            2: begin ex[127:0] = src[127:0]; if (vex) ex[511:128] = '0; end
            3: begin ex[255:0] = src[255:0]; ex[511:256] = '0; end
            4: ex[63:0] = src[63:0];
            5: ex[127:64] = src[63:0];
            default: ex[63:0] = src[127:64];
         endcase
      end
      if (efc == 2) tag = "R12";
      else if (efc == 1) tag = "R6";
      else if (kind == 0) tag = "R13";
      else if (esv) tag = "R9";
      else if (kind == 2) tag = "R10";
      else if (vex) tag = "R11";
      else if (fmt < 2) tag = mem ? "R4" : "R3";
      else if (fmt == 2) tag = "R5";
      else if (fmt == 6) tag = "R8";
      else tag = "R7";

      @(negedge clk);
      op_valid = 1'b1; op_pfx = pfx; op_code = code; op_vex = vex; op_vex_l = l;
      op_src_mem = mem; op_reg = rg; op_rm = rm; op_mem_data = md;
      op_addr_lo = alo; op_len = len; peek_idx = tgt;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      // R2: results appear right after the sampling edge
      chk(fault_valid == efv && (!efv || fault_code == efc), tag, "fault",
          512'({fault_valid, fault_code}), 512'({efv, efc}));
      chk(st_valid == esv && (!esv || st_data == esd), tag, "store",
          512'({st_valid, st_data}), 512'({esv, esd}));
      chk(peek_data == ex, tag, "register", peek_data, ex);
      sh[tgt] = ex;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] codes [11];
      codes = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h16, 8'h17, 8'h28, 8'h29, 8'h6F, 8'h7F, 8'h00};
      for (int i = 0; i < 16; i++) sh[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1
      for (int i = 0; i < 16; i++) begin
         peek_idx = 4'(i);
         #0.5;
         chk(peek_data == '0, "R1", "reset register", peek_data, '0);
      end
      chk(!st_valid && !fault_valid, "R1", "reset outputs",
          512'({st_valid, fault_valid}), '0);
      // Fill the bank with 256-bit vector loads (R11)
      for (int i = 0; i < 16; i++)
         run_op(2'd0, 8'h10, 1'b1, 1'b1, 1'b1, 4'(i), 4'd0, 4'd0, 5'd4);
      for (int p = 0; p < 4; p++)
         for (int c = 0; c < 11; c++)
            for (int v = 0; v < 2; v++)
               for (int l = 0; l < 2; l++)
                  for (int m = 0; m < 2; m++)
                     for (int a = 0; a < 2; a++)
                        for (int n = 0; n < 2; n++)
                           run_op(2'(p), codes[c], 1'(v), 1'(l), 1'(m),
                                  4'($urandom % 16), 4'($urandom % 16),
                                  a ? 4'h8 : 4'h0, n ? 5'd16 : 5'd15);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule